// File: doc/BRIEF.md
# Programmable N-Cycle Delay Line Controller

This block turns a circular line memory into a stream delay of a chosen length. The delay is created by offsetting the read pointer from the write pointer, not by a shift register. A start command carries the requested delay N. If N is inside the legal window, both pointers return to address zero in the same cycle. Writes then run every cycle. Reads are held off for N cycles and after that advance every cycle. Each input sample therefore appears at the output exactly N cycles after it was taken in. The window runs from a parameterised minimum up to the memory depth.

A start with N outside the window is refused. The error flag is raised, and the stream keeps running with the delay it already had. An accepted start given while a previous sequence is still holding or streaming abandons that sequence and begins a new one from address zero.

The stream has no back-pressure. `in_data` is taken on every clock edge once a sequence has been accepted. The consumer must take `out_data` on every cycle in which `out_valid` is high, because the output cannot be stalled. `out_valid` is the only qualifier. There is no ready signal on either side.

Top module: `nd_delay_top`

## Requirements
- R1: While `rst_n` is low, and on the first edge after it rises, `out_valid`, `cfg_err` and `out_data` are 0, and `cur_delay` equals DEPTH.
- R2: A start with MIN_DELAY <= `delay_req` <= DEPTH is accepted. On the next cycle `cur_delay` equals the requested value and `cfg_err` is 0.
- R3: A start with `delay_req` below MIN_DELAY or above DEPTH is rejected. On the next cycle `cfg_err` is 1 and `cur_delay` is unchanged. `cfg_err` keeps its value until the next start.
- R4: A rejected start leaves the running stream untouched: `out_valid` and the delayed data carry on as if no start had been given.
- R5: After an accepted start, `out_valid` is 0 from the next cycle on. `out_data` is 0 whenever `out_valid` is 0.
- R6: If a start is accepted at edge S with delay N, `out_valid` first reads 1 after edge S+N+1.
- R7: While `out_valid` is 1, `out_data` after edge t equals the `in_data` sampled at edge t−N.
- R8: Once high, `out_valid` stays high until the next accepted start.
- R9: An accepted start during the hold phase or the streaming phase restarts the sequence from address zero. Afterwards the output shows only samples taken after that start.
- R10: Both bounds work: N = MIN_DELAY and N = DEPTH each give the exact delay.
- R11: The delay stays correct across any number of pointer wraps through the DEPTH-entry memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle command to begin a sequence with `delay_req` |
| delay_req | input | CNT_W | Requested delay N in cycles |
| in_data | input | DATA_W | Input sample, taken every cycle |
| out_data | output | DATA_W | Delayed sample, 0 when not valid |
| out_valid | output | 1 | Delayed stream valid |
| cfg_err | output | 1 | Last start was rejected |
| cur_delay | output | CNT_W | Delay currently in force |

## Verification
The hardest case to reach from the ports is a restart or a refused request that arrives at an awkward moment. Examples are a refusal while the read side is still being held off, or a new start just before the read pointer would have wrapped. The random phase draws start commands rarely and with requests that straddle both bounds, so these collisions happen at varied offsets inside long runs. Directed runs at the minimum delay and at the full depth then drive the pointers through several wraps.

// File: rtl/nd_pkg.sv
package nd_pkg;
  typedef enum logic [1:0] {
    ND_IDLE = 2'd0,
    ND_HOLD = 2'd1,
    ND_RUN  = 2'd2
  } nd_state_e;
endpackage

// File: rtl/nd_cfg.sv
module nd_cfg #(
  parameter int DEPTH     = 64,
  parameter int MIN_DELAY = 4,
  parameter int CNT_W     = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] delay_req,
  output logic             accept,
  output logic [CNT_W-1:0] cur_delay,
  output logic             cfg_err
);
  // A delay of zero cannot be built from a pointer offset, so the floor is 1.
  localparam int LO = (MIN_DELAY < 1) ? 1 : MIN_DELAY;

  logic in_window;
  assign in_window = (delay_req >= CNT_W'(LO)) && (delay_req <= CNT_W'(DEPTH));
  assign accept    = start && in_window;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_delay <= CNT_W'(DEPTH);
      cfg_err   <= 1'b0;
    end else if (start) begin
      cfg_err <= !in_window;
      if (in_window) cur_delay <= delay_req;
    end
  end
endmodule

// File: rtl/nd_seq.sv
module nd_seq
  import nd_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int CNT_W  = $clog2(DEPTH + 1),
  parameter int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [CNT_W-1:0]  delay_req,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              valid_q
);
  localparam bit POW2 = ((DEPTH & (DEPTH - 1)) == 0);

  nd_state_e         state;
  logic [CNT_W-1:0]  hold_cnt;
  logic [ADDR_W-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;

  // Pointer wrap: a power-of-two depth wraps on overflow, any other depth compares.
  generate
    if (POW2) begin : g_wrap_pow2
      assign wr_nxt = wr_ptr + ADDR_W'(1);
      assign rd_nxt = rd_ptr + ADDR_W'(1);
    end else begin : g_wrap_cmp
      assign wr_nxt = (wr_ptr == ADDR_W'(DEPTH - 1)) ? '0 : wr_ptr + ADDR_W'(1);
      assign rd_nxt = (rd_ptr == ADDR_W'(DEPTH - 1)) ? '0 : rd_ptr + ADDR_W'(1);
    end
  endgenerate

  assign wr_en   = (state != ND_IDLE) && !accept;
  assign rd_en   = (state == ND_RUN) && !accept;
  assign wr_addr = wr_ptr;
  assign rd_addr = rd_ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ND_IDLE;
      hold_cnt <= '0;
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      valid_q  <= 1'b0;
    end else if (accept) begin
      state    <= ND_HOLD;
      hold_cnt <= delay_req;
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      valid_q  <= 1'b0;
    end else begin
      case (state)
        ND_HOLD: begin
          wr_ptr   <= wr_nxt;
          hold_cnt <= hold_cnt - CNT_W'(1);
          if (hold_cnt <= CNT_W'(1)) state <= ND_RUN;
        end
        ND_RUN: begin
          wr_ptr  <= wr_nxt;
          rd_ptr  <= rd_nxt;
          valid_q <= 1'b1;
        end
        default: begin
          state <= ND_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/nd_mem.sv
module nd_mem #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 64,
  parameter int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              clr,
  output logic [DATA_W-1:0] rd_q
);
  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) cells[wr_addr] <= wr_data;
  end

  // A read in the same cycle as a write to the same cell returns the old word.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rd_q <= '0;
    else if (clr)    rd_q <= '0;
    else if (rd_en)  rd_q <= cells[rd_addr];
  end
endmodule

// File: rtl/nd_delay_top.sv
module nd_delay_top #(
  parameter int DATA_W    = 16,
  parameter int DEPTH     = 64,
  parameter int MIN_DELAY = 4,
  parameter int CNT_W     = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  delay_req,
  input  logic [DATA_W-1:0] in_data,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid,
  output logic              cfg_err,
  output logic [CNT_W-1:0]  cur_delay
);
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic              accept, wr_en, rd_en;
  logic [ADDR_W-1:0] wr_addr, rd_addr;

  nd_cfg #(.DEPTH(DEPTH), .MIN_DELAY(MIN_DELAY), .CNT_W(CNT_W)) cfg_i (
    .clk(clk), .rst_n(rst_n), .start(start), .delay_req(delay_req),
    .accept(accept), .cur_delay(cur_delay), .cfg_err(cfg_err)
  );

  nd_seq #(.DEPTH(DEPTH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) seq_i (
    .clk(clk), .rst_n(rst_n), .accept(accept), .delay_req(delay_req),
    .wr_en(wr_en), .wr_addr(wr_addr), .rd_en(rd_en), .rd_addr(rd_addr),
    .valid_q(out_valid)
  );

  nd_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) mem_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(in_data), .rd_en(rd_en), .rd_addr(rd_addr), .clr(accept),
    .rd_q(out_data)
  );
endmodule

// File: rtl/nd_delay_chk.sv
module nd_delay_chk #(
  parameter int DATA_W    = 16,
  parameter int DEPTH     = 64,
  parameter int MIN_DELAY = 4,
  parameter int CNT_W     = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [CNT_W-1:0]  delay_req,
  input logic [DATA_W-1:0] out_data,
  input logic              out_valid,
  input logic              cfg_err,
  input logic [CNT_W-1:0]  cur_delay
);
  logic ok_req, took;
  logic [31:0] since;

  assign ok_req = (int'(delay_req) >= ((MIN_DELAY < 1) ? 1 : MIN_DELAY)) &&
                  (int'(delay_req) <= DEPTH);
  assign took   = start && ok_req;

  // Cycles since the last accepted start, saturating.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  since <= '0;
    else if (took)               since <= '0;
    else if (since != '1)        since <= since + 32'd1;
  end

  p_reset_r1: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && !cfg_err && out_data == '0));

  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    took |=> (cur_delay == $past(delay_req) && !cfg_err));

  p_reject_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !ok_req) |=> (cfg_err && $stable(cur_delay)));

  p_err_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(cfg_err));

  p_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !ok_req && out_valid) |=> out_valid);

  p_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    took |=> !out_valid);

  p_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (out_data == '0));

  p_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (since == 32'(cur_delay) + 32'd1));

  p_no_early_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (since > 32'(cur_delay)));

  p_stay_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !took) |=> out_valid);
endmodule

bind nd_delay_top nd_delay_chk #(
  .DATA_W(DATA_W), .DEPTH(DEPTH), .MIN_DELAY(MIN_DELAY), .CNT_W(CNT_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .delay_req(delay_req),
  .out_data(out_data), .out_valid(out_valid), .cfg_err(cfg_err),
  .cur_delay(cur_delay)
);

// File: tb/nd_delay_top_tb_top.sv
`timescale 1ns/1ps
module nd_delay_top_tb_top;
  localparam int DATA_W    = 16;
  localparam int DEPTH     = 64;
  localparam int MIN_DELAY = 4;
  localparam int CNT_W     = $clog2(DEPTH + 1);
  localparam int HN        = 4096;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [CNT_W-1:0]  delay_req = '0;
  logic [DATA_W-1:0] in_data = '0;
  logic [DATA_W-1:0] out_data;
  logic              out_valid;
  logic              cfg_err;
  logic [CNT_W-1:0]  cur_delay;

  always #2 clk = ~clk;

  nd_delay_top #(.DATA_W(DATA_W), .DEPTH(DEPTH), .MIN_DELAY(MIN_DELAY), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .delay_req(delay_req),
    .in_data(in_data), .out_data(out_data), .out_valid(out_valid),
    .cfg_err(cfg_err), .cur_delay(cur_delay)
  );

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  // Reference state
  logic [DATA_W-1:0] hist [HN];
  int e = 0;
  int s_edge = 0;
  int m_n = DEPTH;
  bit m_act = 0;
  bit m_err = 0;

  function automatic bit legal(input int r);
    return (r >= MIN_DELAY) && (r <= DEPTH);
  endfunction

  function automatic bit exp_valid();
    return m_act && (e >= s_edge + m_n + 1);
  endfunction

  function automatic logic [DATA_W-1:0] exp_data();
    return exp_valid() ? hist[(e - m_n) % HN] : '0;
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s: actual %0h expected %0h (edge %0d)", tag, what, act, exp, e);
    end
  endtask

  // One clock: drive at negedge, update model at posedge, check at next negedge.
  task automatic step(input bit st, input int req, input string tag);
    logic [DATA_W-1:0] d;
    d         = DATA_W'($urandom);
    start     = st;
    delay_req = CNT_W'(req);
    in_data   = d;
    @(posedge clk);
    e++;
    hist[e % HN] = d;
    if (st) begin
      if (legal(req)) begin
        s_edge = e; m_n = req; m_act = 1; m_err = 0;
      end else begin
        m_err = 1;
      end
    end
    @(negedge clk);
    start = 1'b0;
    check({tag, " R6 R8"}, "out_valid", 32'(out_valid), 32'(exp_valid()));
    check({tag, " R7 R5"}, "out_data", 32'(out_data), 32'(exp_data()));
    check({tag, " R3"}, "cfg_err", 32'(cfg_err), 32'(m_err));
    check({tag, " R2"}, "cur_delay", 32'(cur_delay), 32'(m_n));
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, 0, tag);
  endtask

  initial begin
    #(4.0 * 200000);
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    if (!done) $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1: reset values while held in reset and just after release
    check("R1", "out_valid", 32'(out_valid), 32'd0);
    check("R1", "cfg_err", 32'(cfg_err), 32'd0);
    check("R1", "cur_delay", 32'(cur_delay), 32'(DEPTH));
    check("R1", "out_data", 32'(out_data), 32'd0);
    rst_n = 1'b1;
    run(3, "R1");

    // R10: minimum delay, R11: many wraps
    step(1'b1, MIN_DELAY, "R10");
    run(3 * DEPTH, "R10 R11");

    // R4/R3: refused requests while streaming, below and above the window
    step(1'b1, 0, "R4");
    run(8, "R4");
    step(1'b1, MIN_DELAY - 1, "R4");
    run(8, "R4");
    step(1'b1, DEPTH + 1, "R4");
    run(8, "R4");

    // R10/R11: full-depth delay
    step(1'b1, DEPTH, "R10");
    run(4 * DEPTH, "R10 R11");

    // R9: restart during hold, and a refusal during hold
    step(1'b1, 10, "R9");
    run(4, "R9");
    step(1'b1, DEPTH + 5, "R9 R4");
    run(2, "R9");
    step(1'b1, 7, "R9");
    run(30, "R9");

    // R5/R9: restart while streaming
    step(1'b1, 20, "R5 R9");
    run(50, "R5 R9");

    // Random phase
    for (int i = 0; i < 1500; i++) begin
      if ($urandom_range(149) == 0) step(1'b1, int'($urandom_range(DEPTH + 8)), "R7 rnd");
      else                          step(1'b0, 0, "R7 rnd");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule